// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches 28 external input lines and turns activity on them into interrupt requests. Every line passes through a two-flop synchroniser and then a detector. The detector fires on a low level, a high level, a falling edge, a rising edge or either edge, as its trigger field selects. A detected event sets the line's pending bit. The bit stays set until software clears it by writing a one to it.

A mask bit per line decides whether a pending line reaches the outputs. Four request outputs each summarise a fixed, unequally sized range of lines: 0–3, 4–11, 12–19 and 20–27. The downstream interrupt controller takes one request per range. Software reads the pending register and the mask register to find the line that raised the request.

Software reaches the block through a plain register port: a one-cycle write strobe, a 2-bit word address, write data and a combinational read-data bus. There is no back-pressure. Every write is accepted on the clock edge where the strobe is high, and read data is valid in the same cycle as the address.

Top module: `ext_irq_grouper`

## Requirements
- R1: The register port has four words, selected by `bus_addr_i`: 0 = trigger word A (lines 0–15), 1 = trigger word B (lines 16–27), 2 = mask, 3 = pending. A write takes effect on the clock edge where `bus_wr_i` is high. Reads are combinational from `bus_addr_i`. Bit n of the mask and pending words belongs to line n.
- R2: Lines 2k and 2k+1 share one 3-bit trigger field. It sits at bits (k mod 8)*4+2 down to (k mod 8)*4, in word A for k < 8 and in word B otherwise. Bit 3 of each nibble is not stored and reads 0.
- R3: Storage exists only for lines 0–27. Bits 31:24 of trigger word B ignore writes and read 0. Bits 31:28 of the mask and pending words read 0.
- R4: Level triggers: field 000 fires while the synchronised line is low, and 001 fires while it is high.
- R5: Edge triggers: fields 010/011 fire on a falling edge, 100/101 on a rising edge, and 110/111 on both edges. An edge of the opposite direction sets nothing.
- R6: Writing word 3 clears each pending bit written as 1 and leaves the bits written as 0 unchanged.
- R7: `grp_irq_o` bits 0, 1, 2 and 3 are high exactly when a pending, unmasked line lies in 0–3, 4–11, 12–19 or 20–27 respectively.
- R8: A mask bit of 1 blocks the line from its group output but neither clears nor prevents its pending bit.
- R9: After reset the trigger words read 0, the mask reads 0x0FFFFFFF, the pending word reads 0 and `grp_irq_o` is 0.
- R10: A line change made between clock edges shows in the pending word after the third following rising edge, not after the second. The group output follows in the same cycle as the pending bit.
- R11: While a level trigger stays active, the pending bit is set again on every cycle. A clear only sticks once the line is inactive.
- R12: When an event and a clearing write hit the same bit on the same edge, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 28 | Asynchronous external lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| grp_irq_o | output | 4 | Grouped interrupt requests |

## Verification
A line change takes two edges to pass the synchroniser, and the pending bit latches on the third edge. The bench therefore drives lines at a falling clock edge, counts three rising edges and samples at the next falling edge. For R10 it also samples once after only two edges and expects nothing yet. Register writes land on the single edge under the strobe, and reads are sampled one time unit after the address settles. To test R12, the clearing write is placed on the same edge that latches a new event.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  localparam int LINES_N   = 28;
  localparam int WORD_W    = 32;
  localparam int FIELD_W   = 3;
  localparam int STRIDE_W  = 4;
  localparam int GROUPS_N  = 4;
  localparam int ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_TRIG_A = 2'd0,
    REG_TRIG_B = 2'd1,
    REG_MASK   = 2'd2,
    REG_PEND   = 2'd3
  } reg_word_e;

  typedef struct packed {
    logic lvl_en;
    logic lvl_high;
    logic rise_en;
    logic fall_en;
  } trig_ctl_t;

  function automatic trig_ctl_t decode_trig(input logic [FIELD_W-1:0] code);
    trig_ctl_t c;
    c = '0;
    unique case (code[2:1])
      2'b00: begin c.lvl_en = 1'b1; c.lvl_high = code[0]; end
      2'b01: c.fall_en = 1'b1;
      2'b10: c.rise_en = 1'b1;
      default: begin c.rise_en = 1'b1; c.fall_en = 1'b1; end
    endcase
    return c;
  endfunction

  function automatic int grp_first(input int g);
    case (g)
      0: return 0;
      1: return 4;
      2: return 12;
      default: return 20;
    endcase
  endfunction

  function automatic int grp_last(input int g);
    case (g)
      0: return 3;
      1: return 11;
      2: return 19;
      default: return 27;
    endcase
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int N     = LINES_N,
  localparam int PAIRS = (N + 1) / 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             sync_i,
  input  logic [PAIRS*FIELD_W-1:0] trig_i,
  output logic [N-1:0]             evt_o
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    localparam int PAIR = i / 2;
    trig_ctl_t ctl;
    logic      rose;
    logic      fell;

    always_comb begin
      ctl  = decode_trig(trig_i[PAIR*FIELD_W +: FIELD_W]);
      rose = sync_i[i] & ~prev_q[i];
      fell = ~sync_i[i] & prev_q[i];
      if (ctl.lvl_en)
        evt_o[i] = (sync_i[i] == ctl.lvl_high);
      else
        evt_o[i] = (ctl.rise_en & rose) | (ctl.fall_en & fell);
    end
  end

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int N      = LINES_N,
  localparam int PAIRS = (N + 1) / 2,
  localparam int PER_W = WORD_W / STRIDE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [WORD_W-1:0]        wdata_i,
  input  logic [N-1:0]             pend_i,
  output logic [PAIRS*FIELD_W-1:0] trig_o,
  output logic [N-1:0]             mask_o,
  output logic [WORD_W-1:0]        rdata_o
);

  logic [FIELD_W-1:0] trig_q [PAIRS];
  logic [N-1:0]       mask_q;
  logic [WORD_W-1:0]  trig_rd [2];
  logic               unused_wbits;

  assign unused_wbits = ^wdata_i;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    localparam int WSEL = k / PER_W;
    localparam int OFF  = (k % PER_W) * STRIDE_W;
    localparam reg_word_e TARGET = (WSEL == 0) ? REG_TRIG_A : REG_TRIG_B;

    always_ff @(posedge clk) begin
      if (!rst_n)
        trig_q[k] <= '0;
      else if (wr_i && addr_i == TARGET)
        trig_q[k] <= wdata_i[OFF +: FIELD_W];
    end

    assign trig_o[k*FIELD_W +: FIELD_W] = trig_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '1;
    else if (wr_i && addr_i == REG_MASK)
      mask_q <= wdata_i[N-1:0];
  end

  assign mask_o = mask_q;

  always_comb begin
    trig_rd[0] = '0;
    trig_rd[1] = '0;
    for (int k = 0; k < PAIRS; k++)
      trig_rd[k / PER_W][(k % PER_W) * STRIDE_W +: FIELD_W] = trig_q[k];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_TRIG_A: rdata_o = trig_rd[0];
      REG_TRIG_B: rdata_o = trig_rd[1];
      REG_MASK:   rdata_o[N-1:0] = mask_q;
      default:    rdata_o[N-1:0] = pend_i;
    endcase
  end

endmodule

// File: rtl/eirq_pend.sv
module eirq_pend
  import eirq_pkg::*;
#(
  parameter int N = LINES_N
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        evt_i,
  input  logic                clr_wr_i,
  input  logic [N-1:0]        clr_bits_i,
  input  logic [N-1:0]        mask_i,
  output logic [N-1:0]        pend_o,
  output logic [GROUPS_N-1:0] grp_o
);

  logic [N-1:0] pend_q;
  logic [N-1:0] clr_eff;
  logic [N-1:0] live;

  assign clr_eff = clr_wr_i ? clr_bits_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_eff) | evt_i;
  end

  assign pend_o = pend_q;
  assign live   = pend_q & ~mask_i;

  for (genvar g = 0; g < GROUPS_N; g++) begin : g_grp
    localparam int F = grp_first(g);
    localparam int L = grp_last(g);
    assign grp_o[g] = |live[L:F];
  end

endmodule

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper
  import eirq_pkg::*;
#(
  parameter int N = LINES_N
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        line_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [WORD_W-1:0]   bus_wdata_i,
  output logic [WORD_W-1:0]   bus_rdata_o,
  output logic [GROUPS_N-1:0] grp_irq_o
);

  localparam int PAIRS = (N + 1) / 2;

  logic [N-1:0]             sync_vec;
  logic [N-1:0]             evt_vec;
  logic [N-1:0]             pend_vec;
  logic [N-1:0]             mask_vec;
  logic [PAIRS*FIELD_W-1:0] trig_vec;
  logic                     pend_wr;

  assign pend_wr = bus_wr_i && (bus_addr_i == REG_PEND);

  eirq_sync #(.W(N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (line_i),
    .sync_o  (sync_vec)
  );

  eirq_detect #(.N(N)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_vec),
    .trig_i (trig_vec),
    .evt_o  (evt_vec)
  );

  eirq_regs #(.N(N)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .pend_i  (pend_vec),
    .trig_o  (trig_vec),
    .mask_o  (mask_vec),
    .rdata_o (bus_rdata_o)
  );

  eirq_pend #(.N(N)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_vec),
    .clr_wr_i   (pend_wr),
    .clr_bits_i (bus_wdata_i[N-1:0]),
    .mask_i     (mask_vec),
    .pend_o     (pend_vec),
    .grp_o      (grp_irq_o)
  );

endmodule

// File: rtl/eirq_checker.sv
module eirq_checker
  import eirq_pkg::*;
#(
  parameter int N = LINES_N
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [WORD_W-1:0]   bus_wdata_i,
  input logic [WORD_W-1:0]   bus_rdata_o,
  input logic [GROUPS_N-1:0] grp_irq_o,
  input logic [N-1:0]        evt_vec,
  input logic [N-1:0]        pend_vec,
  input logic [N-1:0]        mask_vec
);

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == REG_PEND) |=>
      ((pend_vec & $past(bus_wdata_i[N-1:0] & ~evt_vec)) == '0)); // R6

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> ((pend_vec & $past(evt_vec)) == $past(evt_vec))); // R12

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_i && bus_addr_i == REG_PEND) |=>
      (($past(pend_vec) & ~pend_vec) == '0)); // R8

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec == '1) |-> (grp_irq_o == '0)); // R7

  AST_UPPER_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == REG_TRIG_B) |-> (bus_rdata_o[31:24] == 8'h00)); // R3

  AST_NIBBLE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == REG_TRIG_A) |-> ((bus_rdata_o & 32'h8888_8888) == '0)); // R2

endmodule

bind ext_irq_grouper eirq_checker #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .grp_irq_o   (grp_irq_o),
  .evt_vec     (evt_vec),
  .pend_vec    (pend_vec),
  .mask_vec    (mask_vec)
);

// File: tb/ext_irq_grouper_tb.sv
module ext_irq_grouper_tb_top;

  localparam logic [1:0] A_TA = 2'd0, A_TB = 2'd1, A_MSK = 2'd2, A_PND = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] lines = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  grp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_grouper dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_i      (lines),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .grp_irq_o   (grp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_pend(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(A_PND, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_TA, d);  chk("R9 trig A reset", d, 32'h0);
    rd(A_TB, d);  chk("R9 trig B reset", d, 32'h0);
    rd(A_MSK, d); chk("R9 mask reset", d, 32'h0FFF_FFFF);
    rd(A_PND, d); chk("R9 pend reset", d, 32'h0);
    chk("R9 grp reset", {28'h0, grp}, 32'h0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(A_TA, 32'hFFFF_FFFF);
    rd(A_TA, d);  chk("R1 R2 trig A readback", d, 32'h7777_7777);
    wr(A_TB, 32'hFFFF_FFFF);
    rd(A_TB, d);  chk("R3 trig B upper ignored", d, 32'h0077_7777);
    wr(A_MSK, 32'hFFFF_FFFF);
    rd(A_MSK, d); chk("R3 mask upper zero", d, 32'h0FFF_FFFF);
  endtask

  task automatic t_setup();
    lines = '0;
    wr(A_TA, 32'h4444_4444);
    wr(A_TB, 32'h0044_4444);
    settle();
    wr(A_PND, 32'hFFFF_FFFF);
    chk_pend("R6 clear all", 32'h0);
    wr(A_MSK, 32'h0);
  endtask

  task automatic t_rise();
    lines[5] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_pend("R10 not yet after two edges", 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk_pend("R10 R5 rising sets pend", 32'h0000_0020);
    chk("R7 R10 group 1 up", {28'h0, grp}, 32'h2);
    wr(A_PND, 32'h20);
    lines[5] = 1'b0;
    settle();
    chk_pend("R5 falling ignored in rising mode", 32'h0);
    chk("R7 group idle", {28'h0, grp}, 32'h0);
  endtask

  task automatic t_fall();
    wr(A_TB, 32'h0044_4442);
    lines[17] = 1'b1;
    settle();
    chk_pend("R5 rising ignored in falling mode", 32'h0);
    lines[17] = 1'b0;
    settle();
    chk_pend("R5 R2 falling line 17", 32'h0002_0000);
    chk("R7 group 2", {28'h0, grp}, 32'h4);
    wr(A_PND, 32'h0002_0000);
  endtask

  task automatic t_both();
    wr(A_TB, 32'h0064_4442);
    lines[27] = 1'b1;
    settle();
    chk_pend("R5 R1 both rise line 27", 32'h0800_0000);
    chk("R7 group 3", {28'h0, grp}, 32'h8);
    wr(A_PND, 32'h0800_0000);
    lines[27] = 1'b0;
    settle();
    chk_pend("R5 both fall line 27", 32'h0800_0000);
    wr(A_PND, 32'h0800_0000);
  endtask

  task automatic t_level_high();
    wr(A_TA, 32'h4444_4441);
    lines[0] = 1'b1;
    settle();
    chk_pend("R4 high level", 32'h0000_0001);
    chk("R7 group 0", {28'h0, grp}, 32'h1);
    wr(A_PND, 32'h1);
    chk_pend("R11 clear while active", 32'h0000_0001);
    lines[0] = 1'b0;
    settle();
    wr(A_PND, 32'h1);
    chk_pend("R11 clear after inactive", 32'h0);
  endtask

  task automatic t_level_low();
    wr(A_TA, 32'h4044_4441);
    settle();
    chk_pend("R4 low level 12 13", 32'h0000_3000);
    chk("R7 group 2 from low", {28'h0, grp}, 32'h4);
    lines[13:12] = 2'b11;
    settle();
    wr(A_PND, 32'h3000);
    chk_pend("R4 inactive clears", 32'h0);
    lines[13] = 1'b0;
    settle();
    chk_pend("R4 low only line 13", 32'h0000_2000);
    lines[13] = 1'b1;
    settle();
    wr(A_PND, 32'h2000);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    lines[5] = 1'b1;
    settle();
    wr(A_MSK, 32'h20);
    chk("R8 masked group low", {28'h0, grp}, 32'h0);
    chk_pend("R8 masked pend kept", 32'h0000_0020);
    rd(A_MSK, d); chk("R1 mask readback", d, 32'h20);
    wr(A_MSK, 32'h0);
    chk("R8 unmask restores group", {28'h0, grp}, 32'h2);
    wr(A_PND, 32'h20);
    lines[5] = 1'b0;
    settle();
  endtask

  task automatic t_partial();
    lines[5:4] = 2'b11;
    settle();
    chk_pend("R5 two lines", 32'h0000_0030);
    wr(A_PND, 32'h10);
    chk_pend("R6 zero bits untouched", 32'h0000_0020);
    wr(A_PND, 32'h20);
    lines[5:4] = 2'b00;
    settle();
  endtask

  task automatic t_race();
    lines[20] = 1'b1;
    settle();
    chk_pend("R5 line 20", 32'h0010_0000);
    lines[20] = 1'b0;
    settle();
    lines[20] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr(A_PND, 32'h0010_0000);
    chk_pend("R12 event beats clear", 32'h0010_0000);
    chk("R12 group 3 held", {28'h0, grp}, 32'h8);
    wr(A_PND, 32'h0010_0000);
    chk_pend("R6 later clear", 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_setup();
    t_rise();
    t_fall();
    t_both();
    t_level_high();
    t_level_low();
    t_mask();
    t_partial();
    t_race();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule